// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block holds the running address and the remaining transfer count of one DMA channel and turns them into a physical byte address for every bus cycle the channel performs. Software loads a 16-bit start address and a 16-bit count, each stored at once into a base copy and a working copy. A separately written page register supplies the upper address bits. Each acknowledged transfer advances the working address by one unit and lowers the working count by one. The transfer on which the count passes below zero ends the operation with a one-cycle terminal-count pulse.

A build-time parameter selects the channel width. A byte channel places the page above the 16-bit address, giving 64 KB regions, and enables one byte lane chosen by address bit 0. A word channel shifts the address left by one, drops page bit 0, spans 128 KB regions and enables both lanes. The working address never carries into the page. At terminal count the channel either masks itself or, in auto-initialize mode, reloads its working copies from the base copies and stays enabled.

Top module: `dma_addr_gen`

## Requirements
- R1: With WORD_MODE=0, `phys_addr` equals {page[7:0], current address[15:0]}.
- R2: With WORD_MODE=1, `phys_addr` equals {page[7:1], current address[15:0], 1'b0}, so page bit 0 has no effect and `phys_addr[0]` is always 0.
- R3: Each acknowledged transfer (`xfer_ack` high while `mask` is low) adds one to the 16-bit current address at the clock edge. 0xFFFF wraps to 0x0000 and the page bits stay unchanged.
- R4: An operation loaded with count N performs N+1 acknowledged transfers, with N=0xFFFF giving 65536. `tc` is high for exactly the one cycle after the edge of the acknowledged transfer made while the current count is 0x0000.
- R5: With `auto_init` low, terminal count sets `mask` in the same cycle that `tc` is high. While `mask` is high, `xfer_ack` changes neither the address nor the count, and `tc` stays low.
- R6: With `auto_init` high, terminal count reloads the current address and count from their base copies, and `mask` stays low.
- R7: A page write (`page_wr` high) changes only the page bits of `phys_addr` from the next cycle and leaves the current address untouched.
- R8: With WORD_MODE=0, `byte_en` is 2'b01 when `phys_addr[0]` is 0 and 2'b10 when it is 1. With WORD_MODE=1, `byte_en` is 2'b11.
- R9: After reset, `mask` is 1, `tc` is 0, and the page, address and count are zero.
- R10: `addr_ld` and `cnt_ld` write the value into both the base and the current copy. A load takes priority over a transfer step in the same cycle, and `mask_clr` clears `mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_ld | input | 1 | Load strobe for the start address |
| addr_val | input | 16 | Start address, in units of the channel width |
| cnt_ld | input | 1 | Load strobe for the transfer count |
| cnt_val | input | 16 | Number of transfers minus one |
| page_wr | input | 1 | Write strobe for the page register |
| page_in | input | 8 | Page value |
| auto_init | input | 1 | Reload from the base copies at terminal count instead of masking |
| mask_clr | input | 1 | Clears the channel mask |
| xfer_ack | input | 1 | One strobe per acknowledged transfer cycle |
| phys_addr | output | 24 | Physical byte address of the current transfer |
| byte_en | output | 2 | Byte lane enables for the current transfer |
| tc | output | 1 | Terminal-count pulse |
| mask | output | 1 | Channel disabled |

## Verification
`phys_addr` and `byte_en` decode the registered address and page through logic only. They therefore show the result of a load, page write or transfer step in the cycle right after the edge that took the strobe. `tc` and `mask` are registers themselves, so they show terminal count in that same following cycle. The bench drives each stimulus at a falling edge and queues the outputs it expects for the next rising edge. The monitor compares them a quarter period after that edge, so every expectation covers exactly one register stage. A byte-width and a word-width instance take the same stimulus, which checks both address layouts against one model.

// File: rtl/dma_ag_pkg.sv
// Package dma_ag_pkg
// Shared widths and byte-lane codes for the DMA address sequencer.
// Assumes a two-lane (16-bit) data path.
package dma_ag_pkg;

    localparam int LANES = 2;

    typedef enum logic [LANES-1:0] {
        LANE_LOW  = 2'b01,
        LANE_HIGH = 2'b10,
        LANE_BOTH = 2'b11
    } lane_sel_t;

    // Lane select for a byte transfer from its address bit 0
    function automatic lane_sel_t byte_lane(input logic odd);
        return odd ? LANE_HIGH : LANE_LOW;
    endfunction

endpackage

// File: rtl/dma_ag_ctr.sv
// Module dma_ag_ctr
// Base/current register pair with a single-unit stepping counter.
// The load writes both copies and wins over reload and step.
// A reload copies base into current. The step counts up (DOWN=0) or
// down (DOWN=1) and wraps modulo 2**W.
// Assumes reload and step come from the same acknowledged transfer.
module dma_ag_ctr #(
    parameter int W    = 16,
    parameter bit DOWN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         reload,
    input  logic         step,
    output logic [W-1:0] cur,
    output logic         at_zero
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] base_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] stepped;

    // Next value for one step in the configured direction
    generate
        if (DOWN) begin : g_down
            always_comb stepped = cur_q - ONE;
        end else begin : g_up
            always_comb stepped = cur_q + ONE;
        end
    endgenerate

    // Base copy: changes only on an explicit load
    always_ff @(posedge clk) begin
        if (!rst_n)  base_q <= '0;
        else if (ld) base_q <= ld_val;
    end

    // Current copy: load, then reload, then step
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_q <= '0;
        else if (ld)     cur_q <= ld_val;
        else if (reload) cur_q <= base_q;
        else if (step)   cur_q <= stepped;
    end

    assign cur     = cur_q;
    assign at_zero = (cur_q == '0);

endmodule

// File: rtl/dma_ag_map.sv
// Module dma_ag_map
// Forms the physical byte address and the lane enables from the page and
// the current transfer address. It holds no state.
// WORD_MODE=0: address used as is, page fully used, one lane.
// WORD_MODE=1: address shifted by one, page bit 0 dropped, both lanes.
module dma_ag_map
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 8,
    parameter bit WORD_MODE = 1'b0,
    localparam int PHYS_W   = ADDR_W + PAGE_W
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] addr,
    output logic [PHYS_W-1:0] phys,
    output logic [LANES-1:0]  lanes
);

    generate
        if (WORD_MODE) begin : g_word
            logic page_lsb_unused;
            // Word layout: the unit address lands one bit up
            always_comb begin
                phys  = {page[PAGE_W-1:1], addr, 1'b0};
                lanes = LANE_BOTH;
            end
            assign page_lsb_unused = page[0];
        end else begin : g_byte
            // Byte layout: page sits directly above the address
            always_comb begin
                phys  = {page, addr};
                lanes = byte_lane(addr[0]);
            end
        end
    endgenerate

endmodule

// File: rtl/dma_addr_gen.sv
// Module dma_addr_gen
// Address and count sequencer for one DMA channel.
// Assumes xfer_ack is a single-cycle strobe per bus transfer, and that
// register decoding and arbitration happen outside this block.
// The 16-bit address never carries into the page register.
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 16,
    parameter int PAGE_W    = 8,
    parameter bit WORD_MODE = 1'b0,
    localparam int PHYS_W   = ADDR_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              cnt_ld,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              page_wr,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              auto_init,
    input  logic              mask_clr,
    input  logic              xfer_ack,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [LANES-1:0]  byte_en,
    output logic              tc,
    output logic              mask
);

    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic              cnt_zero;
    logic              addr_zero_unused;
    logic              go;
    logic              last;
    logic              reload;
    logic              mask_q;
    logic              tc_q;

    // Transfer qualifier and terminal-count decode
    always_comb begin
        go     = xfer_ack && !mask_q;
        last   = go && cnt_zero;
        reload = last && auto_init;
    end

    // Page register: written on its own, never touched by the counter
    always_ff @(posedge clk) begin
        if (!rst_n)       page_q <= '0;
        else if (page_wr) page_q <= page_in;
    end

    // Channel mask: set by terminal count without auto-init, cleared on request
    always_ff @(posedge clk) begin
        if (!rst_n)                  mask_q <= 1'b1;
        else if (last && !auto_init) mask_q <= 1'b1;
        else if (mask_clr)           mask_q <= 1'b0;
    end

    // Terminal-count pulse, one cycle after the final transfer
    always_ff @(posedge clk) begin
        if (!rst_n) tc_q <= 1'b0;
        else        tc_q <= last;
    end

    dma_ag_ctr #(
        .W    (ADDR_W),
        .DOWN (1'b0)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (addr_ld),
        .ld_val  (addr_val),
        .reload  (reload),
        .step    (go),
        .cur     (cur_addr),
        .at_zero (addr_zero_unused)
    );

    dma_ag_ctr #(
        .W    (CNT_W),
        .DOWN (1'b1)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (cnt_ld),
        .ld_val  (cnt_val),
        .reload  (reload),
        .step    (go),
        .cur     (cur_cnt),
        .at_zero (cnt_zero)
    );

    dma_ag_map #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .WORD_MODE (WORD_MODE)
    ) u_map (
        .page  (page_q),
        .addr  (cur_addr),
        .phys  (phys_addr),
        .lanes (byte_en)
    );

    assign tc   = tc_q;
    assign mask = mask_q;

endmodule

// File: rtl/dma_addr_gen_chk.sv
// Module dma_addr_gen_chk
// Port-level properties of dma_addr_gen. It is bound into every instance.
module dma_addr_gen_chk #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 8,
    parameter bit WORD_MODE = 1'b0,
    localparam int PHYS_W   = ADDR_W + PAGE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_ld,
    input logic              page_wr,
    input logic [PAGE_W-1:0] page_in,
    input logic              auto_init,
    input logic              xfer_ack,
    input logic [PHYS_W-1:0] phys_addr,
    input logic [1:0]        byte_en,
    input logic              tc,
    input logic              mask
);

    logic [ADDR_W-1:0] unit_addr;

    // Recover the unit address from the physical byte address
    generate
        if (WORD_MODE) begin : g_w
            always_comb unit_addr = phys_addr[ADDR_W:1];
            AST_WORD_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
                page_wr |=> phys_addr[PHYS_W-1:ADDR_W+1] == $past(page_in[PAGE_W-1:1])); // R7
            AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(tc) |-> !phys_addr[0]); // R2
        end else begin : g_b
            always_comb unit_addr = phys_addr[ADDR_W-1:0];
            AST_BYTE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
                page_wr |=> phys_addr[PHYS_W-1:ADDR_W] == $past(page_in)); // R7
            AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(byte_en) == 1); // R8
        end
    endgenerate

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && !mask && !addr_ld && !auto_init) |=> unit_addr == $past(unit_addr) + 1'b1); // R3

    AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !addr_ld && !page_wr) |=> $stable(phys_addr)); // R5

    AST_TC_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !$past(auto_init)) |-> mask); // R5

    AST_TC_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> ($past(xfer_ack) && !$past(mask))); // R4

endmodule

bind dma_addr_gen dma_addr_gen_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W),
    .WORD_MODE (WORD_MODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_ld   (addr_ld),
    .page_wr   (page_wr),
    .page_in   (page_in),
    .auto_init (auto_init),
    .xfer_ack  (xfer_ack),
    .phys_addr (phys_addr),
    .byte_en   (byte_en),
    .tc        (tc),
    .mask      (mask)
);

// File: tb/test_dma_addr_gen.sv
module test_dma_addr_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_ld = 1'b0;
    logic [15:0] addr_val = '0;
    logic        cnt_ld = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        page_wr = 1'b0;
    logic [7:0]  page_in = '0;
    logic        auto_init = 1'b0;
    logic        mask_clr = 1'b0;
    logic        xfer_ack = 1'b0;

    logic [23:0] phys_b, phys_w;
    logic [1:0]  be_b, be_w;
    logic        tc_b, tc_w, mask_b, mask_w;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string       tag;
        logic [23:0] pb;
        logic [1:0]  bb;
        logic [23:0] pw;
        logic        tc;
        logic        mask;
    } exp_t;

    exp_t q[$];
    exp_t e;

    // Reference state, kept from the requirements
    logic [15:0] m_addr = '0, m_base_a = '0, m_cnt = '0, m_base_c = '0;
    logic [7:0]  m_page = '0;
    logic        m_mask = 1'b1, m_tc = 1'b0, m_auto = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_addr_gen #(.WORD_MODE(1'b0)) i_dma_addr_gen (
        .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_val(addr_val),
        .cnt_ld(cnt_ld), .cnt_val(cnt_val), .page_wr(page_wr), .page_in(page_in),
        .auto_init(auto_init), .mask_clr(mask_clr), .xfer_ack(xfer_ack),
        .phys_addr(phys_b), .byte_en(be_b), .tc(tc_b), .mask(mask_b));

    dma_addr_gen #(.WORD_MODE(1'b1)) i_dma_addr_gen_w (
        .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_val(addr_val),
        .cnt_ld(cnt_ld), .cnt_val(cnt_val), .page_wr(page_wr), .page_in(page_in),
        .auto_init(auto_init), .mask_clr(mask_clr), .xfer_ack(xfer_ack),
        .phys_addr(phys_w), .byte_en(be_w), .tc(tc_w), .mask(mask_w));

    task automatic chk(string tag, string what, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void push(string tag);
        exp_t x;
        x.tag  = tag;
        x.pb   = {m_page, m_addr};                 // R1
        x.bb   = m_addr[0] ? 2'b10 : 2'b01;        // R8
        x.pw   = {m_page[7:1], m_addr, 1'b0};      // R2
        x.tc   = m_tc;
        x.mask = m_mask;
        q.push_back(x);
    endfunction

    // Monitor: compares queued expectations after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        while (q.size() > 0) begin
            e = q.pop_front();
            chk(e.tag, "byte phys", phys_b, e.pb);
            chk(e.tag, "byte lanes", {22'd0, be_b}, {22'd0, e.bb});
            chk(e.tag, "word phys", phys_w, e.pw);
            chk(e.tag, "word lanes", {22'd0, be_w}, 24'd3);
            chk(e.tag, "tc", {23'd0, tc_b}, {23'd0, e.tc});
            chk(e.tag, "word tc", {23'd0, tc_w}, {23'd0, e.tc});
            chk(e.tag, "mask", {23'd0, mask_b}, {23'd0, e.mask});
            chk(e.tag, "word mask", {23'd0, mask_w}, {23'd0, e.mask});
        end
    end

    // Driver: one cycle of stimulus, model update, expectation queued
    task automatic step(string tag, bit la, logic [15:0] av, bit lc, logic [15:0] cv,
                        bit lp, logic [7:0] pv, bit mc, bit ack);
        bit go, last;
        @(negedge clk);
        addr_ld = la; addr_val = av; cnt_ld = lc; cnt_val = cv;
        page_wr = lp; page_in = pv; mask_clr = mc; xfer_ack = ack;
        auto_init = m_auto;
        go   = ack && !m_mask;
        last = go && (m_cnt == 16'h0000);
        m_tc = last;
        if (lp) m_page = pv;
        if (la) begin m_addr = av; m_base_a = av; end
        else if (last && m_auto) m_addr = m_base_a;
        else if (go) m_addr = m_addr + 16'd1;
        if (lc) begin m_cnt = cv; m_base_c = cv; end
        else if (last && m_auto) m_cnt = m_base_c;
        else if (go) m_cnt = m_cnt - 16'd1;
        if (last && !m_auto) m_mask = 1'b1;
        else if (mc) m_mask = 1'b0;
        push(tag);
    endtask

    task automatic idle(string tag);           step(tag, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic ack(string tag);            step(tag, 0, 0, 0, 0, 0, 0, 0, 1); endtask
    task automatic ld_a(string tag, logic [15:0] v); step(tag, 1, v, 0, 0, 0, 0, 0, 0); endtask
    task automatic ld_c(string tag, logic [15:0] v); step(tag, 0, 0, 1, v, 0, 0, 0, 0); endtask
    task automatic wpage(string tag, logic [7:0] v); step(tag, 0, 0, 0, 0, 1, v, 0, 0); endtask
    task automatic unmask(string tag);         step(tag, 0, 0, 0, 0, 0, 0, 1, 0); endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        push("R9");                              // reset state
        @(negedge clk);
        rst_n = 1'b1;
        idle("R9");

        ld_a("R10", 16'h1234);
        ld_c("R10", 16'd2);
        wpage("R1", 8'h35);
        ack("R5");                               // masked: ignored
        unmask("R10");
        ack("R3");
        ack("R8");                               // now at odd address
        ack("R4");                               // third transfer, count was 0
        idle("R4");                              // tc gone
        ack("R5");                               // masked again: ignored
        wpage("R7", 8'h36);
        wpage("R2", 8'h37);                      // word view unchanged
        idle("R7");

        ld_a("R3", 16'hFFFF);
        ld_c("R3", 16'd5);
        unmask("R3");
        ack("R3");                               // wraps without touching page
        ack("R3");

        m_auto = 1'b1;
        ld_a("R6", 16'h0100);
        ld_c("R6", 16'd1);
        ack("R6");
        ack("R6");                               // terminal count, reload
        idle("R6");
        ack("R6");
        ack("R6");
        idle("R6");
        m_auto = 1'b0;
        idle("R6");

        ld_c("R4", 16'h0000);
        ack("R4");                               // single transfer
        idle("R5");

        ld_a("R4", 16'h0000);
        ld_c("R4", 16'hFFFF);
        unmask("R4");
        for (int i = 0; i < 65536; i++) ack("R4");
        idle("R4");
        ack("R5");
        idle("R4");

        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not finish");
        finish_run();
    end

endmodule